// File: doc/BRIEF.md
# Shared interrupt line aggregator

This block merges level-sensitive interrupt requests from a set of devices onto four shared interrupt lines. Every device has four request pins. Each device pin is steered to one of the four lines by a rotation that depends on the device's slot position, so pin 0 of neighbouring slots lands on different lines and the load is spread evenly.

The block remembers the level each device pin had at the previous clock edge. When a pin rises or falls, the matching line's counter of asserted sources goes up or down by one. A shared line is held high for as long as its counter is nonzero. When several pins change in one cycle, each counter takes the net sum of all changes routed to it, so no update is lost. The counters are brought out for debug. A synchronous reset clears the counters and the remembered pin levels.

Top module: `irq_share_agg`

## Requirements
- R1: Device d pin p sits at bit 4*d+p of `dev_irq`. Line L is bit L of `line_irq`, and its counter is the field `line_count[L*CW +: CW]`, with CW = clog2(NUM_DEV+1).
- R2: Device d pin p is routed to line (p + d) mod 4.
- R3: The counters change at the first rising clock edge that samples a new input level, and not before it. `line_irq[L]` is high exactly when counter L is nonzero.
- R4: After each edge outside reset, counter L equals the number of device pins routed to L that were high at that edge.
- R5: A pin whose level has not changed since the previous edge has no effect on any counter or line.
- R6: Changes to several pins in the same cycle are applied as one net sum per line. A rise and a fall on the same line in the same cycle leave that counter and line unchanged.
- R7: While `rst` is high at an edge, all counters and stored pin levels go to zero. A pin that is already high when reset is released is counted at the first edge after the release.
- R8: A counter reaches NUM_DEV, and no higher, when every device asserts the pin routed to that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dev_irq | input | NUM_DEV*4 | Device pin levels, four bits per device |
| line_irq | output | 4 | Shared interrupt lines |
| line_count | output | 4*CW | Per-line counters of asserted sources, for debug |

## Verification
A counter that loses or double-counts a change leaves a line stuck high, or low, after the sources have settled. The total of the four counters then no longer matches the number of high input bits, and this shows on `line_count` at the very next edge. A routing error shows as the right total on the wrong line at that same edge. The bench therefore compares every counter field and every line one edge after each stimulus, including the cases with opposing changes in one cycle and pins held high through reset.

// File: rtl/irq_share_agg_pkg.sv
package irq_share_agg_pkg;

    localparam int LINES       = 4;
    localparam int PINS_PER_DEV = 4;

    // slot-rotated routing of a device pin onto a shared line
    function automatic int route_line(input int dev, input int pin);
        return (pin + dev) % LINES;
    endfunction

endpackage

// File: rtl/irq_level_tracker.sv
module irq_level_tracker #(
    parameter int NUM_DEV = 8,
    localparam int W = NUM_DEV * irq_share_agg_pkg::PINS_PER_DEV
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);

    logic [W-1:0] seen_q;

    always_ff @(posedge clk) begin
        if (rst) seen_q <= '0;
        else     seen_q <= lvl_i;
    end

    // a change is the new level minus the remembered one
    assign rise_o = lvl_i & ~seen_q;
    assign fall_o = ~lvl_i & seen_q;

endmodule

// File: rtl/irq_line_router.sv
module irq_line_router #(
    parameter int NUM_DEV = 8,
    parameter int CW      = 4,
    parameter int LINE    = 0,
    localparam int W = NUM_DEV * irq_share_agg_pkg::PINS_PER_DEV
) (
    input  logic [W-1:0]  rise_i,
    input  logic [W-1:0]  fall_i,
    output logic [CW-1:0] up_o,
    output logic [CW-1:0] dn_o
);
    import irq_share_agg_pkg::*;

    always_comb begin
        up_o = '0;
        dn_o = '0;
        for (int d = 0; d < NUM_DEV; d++) begin
            for (int p = 0; p < PINS_PER_DEV; p++) begin
                if (route_line(d, p) == LINE) begin
                    up_o = up_o + CW'(rise_i[d*PINS_PER_DEV + p]);
                    dn_o = dn_o + CW'(fall_i[d*PINS_PER_DEV + p]);
                end
            end
        end
    end

endmodule

// File: rtl/irq_line_counter.sv
module irq_line_counter #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] up_i,
    input  logic [CW-1:0] dn_i,
    output logic [CW-1:0] count_o,
    output logic          active_o
);

    logic [CW-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst) count_q <= '0;
        else     count_q <= count_q + up_i - dn_i;
    end

    assign count_o  = count_q;
    assign active_o = (count_q != '0);

endmodule

// File: rtl/irq_share_agg.sv
module irq_share_agg #(
    parameter int NUM_DEV = 8,
    localparam int W  = NUM_DEV * irq_share_agg_pkg::PINS_PER_DEV,
    localparam int CW = $clog2(NUM_DEV + 1),
    localparam int NL = irq_share_agg_pkg::LINES
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [W-1:0]   dev_irq,
    output logic [NL-1:0]  line_irq,
    output logic [NL*CW-1:0] line_count
);

    logic [W-1:0] rise_w;
    logic [W-1:0] fall_w;

    irq_level_tracker #(.NUM_DEV(NUM_DEV)) u_track (
        .clk    (clk),
        .rst    (rst),
        .lvl_i  (dev_irq),
        .rise_o (rise_w),
        .fall_o (fall_w)
    );

    for (genvar l = 0; l < NL; l++) begin : g_line
        logic [CW-1:0] up_w;
        logic [CW-1:0] dn_w;
        logic [CW-1:0] cnt_w;

        irq_line_router #(.NUM_DEV(NUM_DEV), .CW(CW), .LINE(l)) u_route (
            .rise_i (rise_w),
            .fall_i (fall_w),
            .up_o   (up_w),
            .dn_o   (dn_w)
        );

        irq_line_counter #(.CW(CW)) u_cnt (
            .clk      (clk),
            .rst      (rst),
            .up_i     (up_w),
            .dn_i     (dn_w),
            .count_o  (cnt_w),
            .active_o (line_irq[l])
        );

        assign line_count[l*CW +: CW] = cnt_w;
    end

endmodule

// File: rtl/irq_share_agg_chk.sv
module irq_share_agg_chk #(
    parameter int NUM_DEV = 8,
    localparam int W  = NUM_DEV * 4,
    localparam int CW = $clog2(NUM_DEV + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic [W-1:0]     dev_irq,
    input logic [3:0]       line_irq,
    input logic [4*CW-1:0]  line_count
);

    int   sum_counts;
    logic any_over;

    always_comb begin
        sum_counts = 0;
        any_over   = 1'b0;
        for (int l = 0; l < 4; l++) begin
            sum_counts = sum_counts + int'(line_count[l*CW +: CW]);
            if (int'(line_count[l*CW +: CW]) > NUM_DEV) any_over = 1'b1;
        end
    end

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        !any_over);

    // R7
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (line_count == '0));

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $stable(dev_irq)) |=> $stable(line_count));

    // R4
    total_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (sum_counts == $countones($past(dev_irq))));

    // R3
    quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (dev_irq == '0) |=> (line_irq == 4'b0000));

endmodule

bind irq_share_agg irq_share_agg_chk #(.NUM_DEV(NUM_DEV)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .dev_irq    (dev_irq),
    .line_irq   (line_irq),
    .line_count (line_count)
);

// File: tb/tb_irq_share_agg.sv
`timescale 1ns/1ps
module tb_irq_share_agg;

    localparam int NUM_DEV = 8;
    localparam int W  = NUM_DEV * 4;
    localparam int CW = $clog2(NUM_DEV + 1);
    localparam int NV = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [W-1:0]      dev_irq = '0;
    logic [3:0]        line_irq;
    logic [4*CW-1:0]   line_count;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    irq_share_agg #(.NUM_DEV(NUM_DEV)) dut (
        .clk        (clk),
        .rst        (rst),
        .dev_irq    (dev_irq),
        .line_irq   (line_irq),
        .line_count (line_count)
    );

    // stimulus and hand-worked line masks (R2: line = (pin + dev) mod 4)
    localparam logic [W-1:0] STIM [NV] = '{
        32'h0000_0000, 32'h0000_0001, 32'h0000_0010, 32'h0000_0030,
        32'h8000_0000, 32'h1111_1111, 32'h8888_8888, 32'h0000_1248,
        32'hFFFF_FFFF, 32'h0000_0000 };
    localparam logic [3:0] MASK [NV] = '{
        4'b0000, 4'b0001, 4'b0010, 4'b0110,
        4'b0100, 4'b1111, 4'b1111, 4'b1000,
        4'b1111, 4'b0000 };

    // model of R1/R2/R4: per-line count of high pins
    function automatic logic [4*CW-1:0] model_counts(input logic [W-1:0] v);
        logic [4*CW-1:0] r = '0;
        for (int d = 0; d < NUM_DEV; d++)
            for (int p = 0; p < 4; p++)
                if (v[d*4 + p]) begin
                    int l = (p + d) % 4;
                    r[l*CW +: CW] = r[l*CW +: CW] + CW'(1);
                end
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [W-1:0] v);
        @(negedge clk);
        dev_irq = v;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R7 reset counts", 32'(line_count), 32'h0);
        chk("R7 reset lines", 32'(line_irq), 32'h0);
        rst = 1'b0;
        @(negedge clk);

        // table walk
        for (int i = 0; i < NV; i++) begin
            step(STIM[i]);
            chk("R2 line mask", 32'(line_irq), 32'(MASK[i]));
            chk("R4 counts", 32'(line_count), 32'(model_counts(STIM[i])));
        end

        // R1: device 2 pin 0 lands in counter field of line 2 (bits 8..11)
        step(32'h0000_0100);
        chk("R1 field layout", 32'(line_count), 32'h0000_0100);

        // R3: no change before the sampling edge, change right after it
        step(32'h0000_0000);
        @(negedge clk);
        dev_irq = 32'h0000_0001;
        #1;
        chk("R3 before edge", 32'(line_irq), 32'h0);
        @(negedge clk);
        chk("R3 after edge", 32'(line_irq), 32'h1);

        // R6: d0p0 falls and d1p3 rises, both on line 0
        step(32'h0000_0080);
        chk("R6 opposite same line", 32'(line_count), 32'h0000_0001);
        step(32'h2222_2222);
        chk("R6 many at once", 32'(line_count), 32'(model_counts(32'h2222_2222)));

        // R5: held inputs leave counters untouched
        step(32'h0000_1248);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R5 hold", 32'(line_count), 32'h0000_4000);
        end

        // R8: all pins high gives NUM_DEV on every line
        step(32'hFFFF_FFFF);
        chk("R8 full count", 32'(line_count), 32'h0000_8888);

        // R7: pins high through reset, counted after release
        @(negedge clk);
        rst = 1'b1;
        dev_irq = 32'h0000_000F;
        @(negedge clk);
        chk("R7 cleared in reset", 32'(line_count), 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk("R7 counted after release", 32'(line_count), 32'h0000_1111);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog R3 actual=timeout expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule